// File: doc/BRIEF.md
# I2C Master Receive Engine with Byte-Level Wait

This block is the receive half of an I2C master. Its SCL clock comes from a divider on the system clock. It shifts in one byte per frame from SDA and returns an acknowledge bit on the ninth clock. Software drives it through a small register port with three addresses: a data register, a control register and a status register. An interrupt output tells software when it needs attention.

Reception starts when software reads the data register while the block is idle and in receive mode. That first read returns no useful data. From then on the engine clocks frame after frame until a switch to transmit mode takes effect. The switch only lands at the rising edge of a ninth clock.

With wait mode on, the engine parks SCL low after the last data bit and raises the interrupt flag. Software can then choose ACK or NACK for that byte before it goes out on the bus. Clearing the flag releases the ninth clock.

Top module: `i2c_rxw_top`

## Requirements
- R1: After reset, SCL and SDA are released, the interrupt output is low, the status register reads 0, and the control register reads 1, which selects transmit mode.
- R2: SCL stays released unless a read of the data register (address 0) arrives while the engine is idle and the mode bit is 0 (receive). A data read in transmit mode starts nothing.
- R3: Data bits are sampled MSB first on the rising edges of SCL. After a frame, the data register (address 0) reads the received byte.
- R4: With wait enabled (control bit 2), the interrupt flag (status bit 0) is set at the falling edge of the last data clock. SCL is then held low for as long as the flag stays set, and no acknowledge clock is issued.
- R5: During the ninth clock, SDA is driven low when the ack bit (control bit 3) is 0 and released when it is 1. The value used is the one present when the ninth clock's low phase begins.
- R6: At the rising edge of the ninth clock, the interrupt flag, the receive-done flag (status bit 1) and the data-full flag (status bit 2) are all set.
- R7: Reading the data register clears the data-full flag.
- R8: Writing the status register with bit 0 equal to 0 clears both the interrupt flag and the receive-done flag.
- R9: A write of the mode bit (control bit 0) made while a frame is in progress is not visible in the control register until the next ninth-clock rising edge. After a frame that ends in transmit mode, the engine stops clocking.
- R10: The interrupt output equals the interrupt flag ANDed with the enable bit (control bit 1).
- R11: With wait disabled, frames follow each other with no stall. Every SCL low phase, including the acknowledge clock, lasts exactly T_LOW system clocks.
- R12: Inside a frame, every SCL high phase lasts T_HIGH system clocks. Every low phase outside the wait point lasts T_LOW system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects on the data register) |
| reg_addr_i | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench holds the engine at the wait point for a long stretch. A design that failed to stall would let SCL rise or move the slave model on to the next byte. The bench also writes transmit mode and NACK in the middle of a frame. A mode bit applied early would show up in the readback or would cut off the final acknowledge clock. An ACK value latched at the wrong moment would put the wrong level on SDA during the ninth clock. A bus monitor measures every SCL phase. In wait-free operation, any stall, or a divider that is off by one, shows up as a phase of the wrong length. A data read in transmit mode must leave the bus idle, so a start that ignores the mode bit would produce a clock.

// File: rtl/i2c_rxw_pkg.sv
package i2c_rxw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_WAIT = 2'd3
  } eng_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control bit positions
  localparam int unsigned CTRL_TX   = 0;
  localparam int unsigned CTRL_IE   = 1;
  localparam int unsigned CTRL_WAIT = 2;
  localparam int unsigned CTRL_NACK = 3;

endpackage

// File: rtl/i2c_rxw_engine.sv
module i2c_rxw_engine
  import i2c_rxw_pkg::*;
#(
  parameter int unsigned NBITS  = 8,
  parameter int unsigned T_LOW  = 8,
  parameter int unsigned T_HIGH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wait_en_i,
  input  logic             nack_i,
  input  logic             int_flag_i,
  input  logic             mode_tx_i,
  input  logic             sda_i,
  output logic             busy_o,
  output logic             ev_wait_o,
  output logic             ev_frame_o,
  output logic [NBITS-1:0] data_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);

  localparam int unsigned T_MAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);
  localparam int unsigned BI_W  = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(T_LOW - 1);
  localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(T_HIGH - 1);
  localparam logic [BI_W-1:0]  ACK_IDX  = BI_W'(NBITS);
  localparam logic [BI_W-1:0]  LAST_IDX = BI_W'(NBITS - 1);

  eng_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BI_W-1:0]  bit_q;
  logic [NBITS-1:0] shift_q;
  logic             ack_drv_q;
  logic             low_done, high_done;

  assign low_done   = (state_q == ST_LOW)  && (cnt_q == LOW_END);
  assign high_done  = (state_q == ST_HIGH) && (cnt_q == HIGH_END);
  assign ev_frame_o = low_done && (bit_q == ACK_IDX);
  assign ev_wait_o  = high_done && (bit_q == LAST_IDX) && wait_en_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign scl_oe_o   = (state_q == ST_LOW) || (state_q == ST_WAIT);
  assign sda_oe_o   = ack_drv_q;
  assign data_o     = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      ack_drv_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
            bit_q   <= '0;
          end
        end
        ST_LOW: begin
          if (low_done) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
            if (bit_q != ACK_IDX) shift_q <= {shift_q[NBITS-2:0], sda_i};
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (high_done) begin
            cnt_q <= '0;
            if (bit_q == LAST_IDX) begin
              if (wait_en_i) begin
                state_q <= ST_WAIT;
              end else begin
                state_q   <= ST_LOW;
                bit_q     <= ACK_IDX;
                ack_drv_q <= ~nack_i;
              end
            end else if (bit_q == ACK_IDX) begin
              ack_drv_q <= 1'b0;
              state_q   <= mode_tx_i ? ST_IDLE : ST_LOW;
              bit_q     <= '0;
            end else begin
              state_q <= ST_LOW;
              bit_q   <= bit_q + BI_W'(1);
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          // held low until software clears the flag
          if (!int_flag_i) begin
            state_q   <= ST_LOW;
            cnt_q     <= '0;
            bit_q     <= ACK_IDX;
            ack_drv_q <= ~nack_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_wait_until_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && int_flag_i) |=> (state_q == ST_WAIT));

  assert_idle_no_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));

  assert_ack_only_ninth_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (bit_q == ACK_IDX));

endmodule

// File: rtl/i2c_rxw_regs.sv
module i2c_rxw_regs
  import i2c_rxw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          ev_wait_i,
  input  logic          ev_frame_i,
  input  logic [DW-1:0] rx_byte_i,
  output logic          irq_o,
  output logic          start_o,
  output logic          wait_en_o,
  output logic          nack_o,
  output logic          int_flag_o,
  output logic          mode_tx_o
);

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] data_q;
  logic          mode_eff_q;
  logic          int_q, done_q, full_q;
  logic          wr_ctrl, clr_int, rd_data;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign clr_int = we_i && (addr_i == ADDR_STAT) && !wdata_i[0];
  assign rd_data = re_i && (addr_i == ADDR_DATA);

  assign start_o    = rd_data && !busy_i && !mode_eff_q;
  assign irq_o      = int_q && ctrl_q[CTRL_IE];
  assign wait_en_o  = ctrl_q[CTRL_WAIT];
  assign nack_o     = ctrl_q[CTRL_NACK];
  assign int_flag_o = int_q;
  assign mode_tx_o  = mode_eff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= DW'(1);
      mode_eff_q <= 1'b1;
      data_q     <= '0;
      int_q      <= 1'b0;
      done_q     <= 1'b0;
      full_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      // mode changes at once when idle, otherwise at the ninth rising edge
      if (wr_ctrl && !busy_i)  mode_eff_q <= wdata_i[CTRL_TX];
      else if (ev_frame_i)     mode_eff_q <= wr_ctrl ? wdata_i[CTRL_TX] : ctrl_q[CTRL_TX];

      if (ev_frame_i) data_q <= rx_byte_i;

      if (ev_wait_i || ev_frame_i) int_q <= 1'b1;
      else if (clr_int)            int_q <= 1'b0;

      if (ev_frame_i)   done_q <= 1'b1;
      else if (clr_int) done_q <= 1'b0;

      if (ev_frame_i)   full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = data_q;
      ADDR_CTRL: rdata_o = {ctrl_q[DW-1:1], mode_eff_q};
      ADDR_STAT: rdata_o = {{(DW-3){1'b0}}, full_q, done_q, int_q};
      default:   rdata_o = '0;
    endcase
  end

  assert_frame_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_frame_i |=> (int_q && done_q && full_q));

  assert_mode_deferred_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !ev_frame_i) |=> $stable(mode_eff_q));

  assert_clear_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_int && !ev_frame_i && !ev_wait_i) |=> (!done_q && !int_q));

  assert_read_clears_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !ev_frame_i) |=> !full_q);

endmodule

// File: rtl/i2c_rxw_top.sv
module i2c_rxw_top #(
  parameter int unsigned NBITS  = 8,
  parameter int unsigned T_LOW  = 8,
  parameter int unsigned T_HIGH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [NBITS-1:0] reg_wdata_i,
  output logic [NBITS-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);

  logic             busy, ev_wait, ev_frame, start, wait_en, nack, int_flag, mode_tx;
  logic [NBITS-1:0] rx_byte;

  i2c_rxw_regs #(.DW(NBITS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .ev_wait_i  (ev_wait),
    .ev_frame_i (ev_frame),
    .rx_byte_i  (rx_byte),
    .irq_o      (irq_o),
    .start_o    (start),
    .wait_en_o  (wait_en),
    .nack_o     (nack),
    .int_flag_o (int_flag),
    .mode_tx_o  (mode_tx)
  );

  i2c_rxw_engine #(.NBITS(NBITS), .T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wait_en_i  (wait_en),
    .nack_i     (nack),
    .int_flag_i (int_flag),
    .mode_tx_i  (mode_tx),
    .sda_i      (sda_i),
    .busy_o     (busy),
    .ev_wait_o  (ev_wait),
    .ev_frame_o (ev_frame),
    .data_o     (rx_byte),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

endmodule

// File: tb/tb_i2c_rxw_top.sv
`timescale 1ns/1ps
module tb_i2c_rxw_top;

  localparam int T_LOW  = 8;
  localparam int T_HIGH = 6;
  localparam int NV     = 6;
  // {byte[9:2], wait[1], last[0]}
  localparam logic [9:0] VEC [NV] = '{
    {8'hA5, 1'b1, 1'b0},
    {8'h3C, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1},
    {8'h81, 1'b0, 1'b0},
    {8'h5E, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe, sda_line;
  logic       slave_oe = 1'b0;

  int n_chk = 0, n_fail = 0;
  int fidx = 0, k = 0;
  int run_len = 0, high_bad = 0, low_bad = 0, nw_bad = 0, high_seen = 0, nw_seen = 0;
  logic prev_scl = 1'b0, nowait_phase = 1'b0, finished = 1'b0;
  logic ack_cap [NV];

  always #10 clk = ~clk;

  assign sda_line = ~(sda_oe | slave_oe);

  i2c_rxw_top #(.NBITS(8), .T_LOW(T_LOW), .T_HIGH(T_HIGH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // slave model and SCL phase monitor
  initial begin
    forever begin
      @(negedge clk);
      if (scl_oe !== prev_scl) begin
        if (scl_oe) begin
          if (k != 0) begin
            high_seen++;
            if (run_len != T_HIGH) high_bad++;
          end
          slave_oe = (k < 8 && fidx < NV) ? ~VEC[fidx][2 + 7 - k] : 1'b0;
        end else begin
          if (k != 8 && run_len != T_LOW) low_bad++;
          if (nowait_phase) begin
            nw_seen++;
            if (run_len != T_LOW) nw_bad++;
          end
          if (k == 8) begin
            if (fidx < NV) ack_cap[fidx] = ~sda_oe;
            fidx++;
            k = 0;
          end else k++;
        end
        run_len = 1;
        prev_scl = scl_oe;
      end else run_len++;
    end
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] s, c, d;
    logic       w, last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl", scl_oe, 0);
    chk("R1 sda", sda_oe, 0);
    chk("R1 irq", irq, 0);
    rd(2'd2, s); chk("R1 stat", s, 8'h00);
    rd(2'd1, c); chk("R1 ctrl", c, 8'h01);

    for (int i = 0; i < NV; i++) begin
      w    = VEC[i][1];
      last = VEC[i][0];
      if (i == 0 || VEC[i-1][0]) begin
        nowait_phase = !w;
        wr(2'd1, w ? 8'h06 : 8'h00);
        repeat (30) @(negedge clk);
        chk("R2 no clock before dummy read", scl_oe, 0);
        rd(2'd0, d);
      end
      if (w) begin
        wait_irq();
        rd(2'd2, s); chk("R4 wait point flags", s[1:0], 2'b01);
        repeat (40) @(negedge clk);
        chk("R4 scl held low", scl_oe, 1);
        chk("R4 irq held", irq, 1);
        chk("R4 no ninth clock", fidx, i);
        wr(2'd1, last ? 8'h0F : 8'h06);
        if (last) begin rd(2'd1, c); chk("R9 mode deferred", c[0], 0); end
        wr(2'd2, 8'h00);
        wait_irq();
        rd(2'd2, s); chk("R6 frame flags", s[2:0], 3'b111);
        if (last) begin rd(2'd1, c); chk("R9 mode applied", c[0], 1); end
        rd(2'd0, d); chk("R3 data", d, VEC[i][9:2]);
        rd(2'd2, s); chk("R7 full cleared", s[2], 0);
        wr(2'd2, 8'h00);
        rd(2'd2, s); chk("R8 done cleared", s[1:0], 2'b00);
      end else begin
        s = 8'h00;
        while (!s[1]) rd(2'd2, s);
        chk("R10 irq masked", irq, 0);
        chk("R11 flag set", s[0], 1);
        rd(2'd0, d); chk("R11 R3 data", d, VEC[i][9:2]);
        if (!last && VEC[i+1][0]) begin
          wr(2'd1, 8'h09);
          rd(2'd1, c); chk("R9 mode deferred", c[0], 0);
        end
        wr(2'd2, 8'h00);
      end
      while (fidx <= i) @(negedge clk);
      chk("R5 ack value", ack_cap[i], last);
      if (last) begin
        repeat (80) @(negedge clk);
        chk("R9 stops clocking", scl_oe, 0);
        chk("R9 frame count", fidx, i + 1);
        nowait_phase = 1'b0;
      end
    end

    rd(2'd0, d);
    repeat (60) @(negedge clk);
    chk("R2 read in transmit mode ignored", scl_oe, 0);
    chk("R12 high phases", high_bad, 0);
    chk("R12 low phases", low_bad, 0);
    chk("R12 phases seen", high_seen > 40, 1);
    chk("R11 no stall", nw_bad, 0);
    chk("R11 phases seen", nw_seen > 10, 1);
    summary();
  end

endmodule